// File: doc/BRIEF.md
# Pipelined Register Bus Master

This block turns commands from an upstream memory-mapped port into transfers on a synchronous, decoded 32-bit register bus. The register bus runs on the same system clock as the rest of the block. A command names a direction (read or write), a start word address and a burst length. The block then drives one bus transfer per beat, with the address stepping by one word each beat, and never more than one transfer in any clock.

Write beats take their data from an upstream data stream with a valid/ready handshake. A write is finished in the cycle it is issued. Read beats go out back to back while the external side keeps up. The external side may return each read word after any pipeline delay, provided the words come back in issue order with a qualifying strobe. A credit counter caps the number of reads in flight and holds further read beats when the cap is reached. Each returned word is passed upstream through one register stage, in the order it arrived. Upstream back-pressure uses the command ready signal, which stays low for the whole of a burst.

Top module: `regbus_master`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `bus_rd`, `bus_wr` and `rsp_valid` are 0.
- R2: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both 1. From the next cycle, `cmd_ready` stays 0 until the cycle that issues the last beat, and it is 1 again in the cycle after that. Commands presented while `cmd_ready` is 0 have no effect.
- R3: `bus_rd` and `bus_wr` are never 1 in the same cycle.
- R4: A command with length field L issues exactly L+1 beats. The first beat uses `cmd_addr`, and each later beat uses the previous address plus one. A length field of 0 gives one beat.
- R5: While fewer than MAX_OUT reads are outstanding, the beats of a read burst go out in consecutive cycles, so the last beat comes L cycles after the first.
- R6: During a write burst `wr_ready` is 1. A write beat goes out (`bus_wr` = 1, `bus_wdata` = `wr_data`) only in a cycle with `wr_valid` = 1. A cycle with `wr_valid` = 0 issues nothing and leaves the address unchanged.
- R7: The number of reads issued but not yet returned never exceeds MAX_OUT (16 by default). When it reaches MAX_OUT, read beats stop until words return, and the burst then completes.
- R8: A word presented with `bus_rvalid` = 1 appears on `rsp_data` with `rsp_valid` = 1 exactly one cycle later. Words leave in the order they arrived, which matches the order of the read addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared with the register bus |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Upstream command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | AW (16) | Start word address |
| cmd_len | input | LW (8) | Burst length minus one |
| wr_valid | input | 1 | Upstream write word present |
| wr_ready | output | 1 | Block is in a write burst and takes words |
| wr_data | input | 32 | Upstream write word |
| rsp_valid | output | 1 | Read word delivered upstream |
| rsp_data | output | 32 | Read word upstream |
| bus_rd | output | 1 | Read strobe on the register bus |
| bus_wr | output | 1 | Write strobe on the register bus |
| bus_addr | output | AW (16) | Register bus word address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rvalid | input | 1 | Returned read word is valid |
| bus_rdata | input | 32 | Returned read word |

## Verification
The bus strobes and the address are combinational from the burst state, so a beat appears in the same cycle as its enable. The first beat shows in the cycle after the command is taken. A returned word reaches `rsp_data` one cycle after `bus_rvalid`, and `cmd_ready` rises one cycle after the last beat. The bench drives inputs on falling edges and samples on the following falling edge. It records the cycle number of every read beat so the spacing can be compared with the length field. A bench-side responder whose return enable can be held off makes the credit stall occur, and it also gives read latencies longer than one cycle.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_RD   = 2'd1,
    KIND_WR   = 2'd2
  } beat_kind_t;

  // selects which transfer, if any, a cycle carries
  function automatic beat_kind_t pick_kind(input logic busy, input logic is_wr,
                                           input logic wdat_ok, input logic credit_ok);
    if (!busy)        return KIND_IDLE;
    else if (is_wr)   return wdat_ok   ? KIND_WR : KIND_IDLE;
    else              return credit_ok ? KIND_RD : KIND_IDLE;
  endfunction

endpackage

// File: rtl/rbm_seq.sv
module rbm_seq
  import rbm_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          credit_ok,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic          burst_done
);

  localparam logic [AW-1:0] ADDR_STEP = AW'(1);
  localparam logic [LW-1:0] LEN_STEP  = LW'(1);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + ADDR_STEP;
  endfunction

  logic          busy, is_wr;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] rem;
  beat_kind_t    kind;
  logic          accept, beat, last_beat;

  assign kind       = pick_kind(busy, is_wr, wr_valid, credit_ok);
  assign cmd_ready  = !busy;
  assign accept     = cmd_valid && !busy;
  assign wr_ready   = busy && is_wr;
  assign bus_rd     = (kind == KIND_RD);
  assign bus_wr     = (kind == KIND_WR);
  assign bus_addr   = cur_addr;
  assign beat       = bus_rd || bus_wr;
  assign last_beat  = (rem == '0);
  assign burst_done = beat && last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_wr    <= 1'b0;
      cur_addr <= '0;
      rem      <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      is_wr    <= cmd_write;
      cur_addr <= cmd_addr;
      rem      <= cmd_len;
    end else if (beat) begin
      cur_addr <= step_addr(cur_addr);
      rem      <= rem - LEN_STEP;
      if (last_beat) busy <= 1'b0;
    end
  end

  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last_beat) |=> (bus_addr == $past(bus_addr) + ADDR_STEP)); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> $stable(bus_addr)); // R6
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> cmd_ready); // R2

endmodule

// File: rtl/rbm_credit.sv
module rbm_credit #(
  parameter int MAX_OUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_issue,
  input  logic rd_ret,
  output logic credit_ok
);

  localparam int CW = $clog2(MAX_OUT + 1);
  localparam logic [CW-1:0] FULL = CW'(MAX_OUT);

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic up, input logic dn);
    logic [CW-1:0] r;
    r = c;
    if (up && !dn)      r = c + CW'(1);
    else if (dn && !up) r = c - CW'(1);
    return r;
  endfunction

  logic [CW-1:0] inflight;

  assign credit_ok = (inflight < FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= next_count(inflight, rd_issue, rd_ret);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) inflight <= FULL); // R7
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == FULL && !rd_ret) |=> !rd_issue || (inflight < FULL)); // R7

endmodule

// File: rtl/rbm_rsp.sv
module rbm_rsp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_data == $past(in_data))); // R8

endmodule

// File: rtl/regbus_master.sv
module regbus_master #(
  parameter int AW      = 16,
  parameter int LW      = 8,
  parameter int DW      = 32,
  parameter int MAX_OUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_rvalid,
  input  logic [DW-1:0] bus_rdata
);

  logic credit_ok;
  logic burst_done;

  assign bus_wdata = wr_data;

  rbm_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .credit_ok(credit_ok),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .burst_done(burst_done)
  );

  rbm_credit #(.MAX_OUT(MAX_OUT)) u_credit (
    .clk(clk), .rst_n(rst_n),
    .rd_issue(bus_rd), .rd_ret(bus_rvalid), .credit_ok(credit_ok)
  );

  rbm_rsp #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(bus_rvalid), .in_data(bus_rdata),
    .out_valid(rsp_valid), .out_data(rsp_data)
  );

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && !burst_done |=> !cmd_ready); // R2

endmodule

// File: tb/sim_regbus_master.sv
`timescale 1ns/1ps
module sim_regbus_master;
  localparam int AW = 16, LW = 8, DW = 32, MAX_OUT = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic cmd_ready, wr_ready, rsp_valid, bus_rd, bus_wr;
  logic [DW-1:0] rsp_data, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic bus_rvalid;
  logic [DW-1:0] bus_rdata;

  always #2.5 clk = ~clk;

  regbus_master #(.AW(AW), .LW(LW), .DW(DW), .MAX_OUT(MAX_OUT)) u0 (.*);

  int checks = 0, errors = 0;
  logic done = 1'b0;

  function automatic logic [DW-1:0] reg_val(input logic [AW-1:0] a);
    return {a ^ 16'hC3A5, a};
  endfunction
  function automatic logic [DW-1:0] wdat(input int k);
    return 32'hD000_0000 + DW'(k * 7);
  endfunction

  // external responder: in-order queue with a hold-off switch
  logic ret_en = 1'b1;
  logic [DW-1:0] q [0:63];
  int qw = 0, qr = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0; bus_rdata <= '0; qw = 0; qr = 0;
    end else begin
      if (ret_en && qw > qr) begin
        bus_rvalid <= 1'b1; bus_rdata <= q[qr % 64]; qr = qr + 1;
      end else bus_rvalid <= 1'b0;
      if (bus_rd) begin q[qw % 64] = reg_val(bus_addr); qw = qw + 1; end
    end
  end

  // monitor at falling edges
  int cyc = 0;
  logic [AW-1:0] rd_a [0:255]; int rd_c [0:255]; int rd_n = 0;
  logic [DW-1:0] rs_d [0:255]; int rs_n = 0;
  logic [AW-1:0] wr_a [0:255]; logic [DW-1:0] wr_d [0:255]; int wr_n = 0;
  int rv_n = 0, v_both = 0, v_out = 0, v_lat = 0;
  logic p_rv = 1'b0; logic [DW-1:0] p_rd = '0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (bus_rd && bus_wr) v_both = v_both + 1;
      if (bus_rd) begin rd_a[rd_n % 256] = bus_addr; rd_c[rd_n % 256] = cyc; rd_n = rd_n + 1; end
      if (bus_wr) begin wr_a[wr_n % 256] = bus_addr; wr_d[wr_n % 256] = bus_wdata; wr_n = wr_n + 1; end
      if (rsp_valid) begin rs_d[rs_n % 256] = rsp_data; rs_n = rs_n + 1; end
      if (rsp_valid !== p_rv || (p_rv && rsp_data !== p_rd)) v_lat = v_lat + 1;
      if (bus_rvalid) rv_n = rv_n + 1;
      if (rd_n - rv_n > MAX_OUT) v_out = v_out + 1;
      p_rv = bus_rvalid; p_rd = bus_rdata;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic w, input logic [AW-1:0] a, input logic [LW-1:0] l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_len = l;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2 busy after accept", cmd_ready, 0);
  endtask

  task automatic wait_idle(input int exp_rs);
    int n = 0;
    while ((!cmd_ready || rs_n < exp_rs) && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(!bus_rd && !bus_wr, "R1 strobes", {bus_rd, bus_wr}, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input int len);
    int r0 = rd_n, s0 = rs_n; logic ok = 1'b1; logic okd = 1'b1;
    send(1'b0, a, LW'(len));
    wait_idle(s0 + len + 1);
    chk(rd_n - r0 == len + 1, "R4 read beat count", rd_n - r0, len + 1);
    for (int i = 0; i <= len; i++) if (rd_a[(r0 + i) % 256] != a + AW'(i)) ok = 1'b0;
    chk(ok, "R4 read addresses", rd_a[r0 % 256], a);
    chk(rd_c[(r0 + len) % 256] - rd_c[r0 % 256] == len, "R5 back to back",
        rd_c[(r0 + len) % 256] - rd_c[r0 % 256], len);
    for (int i = 0; i <= len; i++) if (rs_d[(s0 + i) % 256] != reg_val(a + AW'(i))) okd = 1'b0;
    chk(okd && rs_n - s0 == len + 1, "R8 read data order", rs_d[s0 % 256], reg_val(a));
    chk(cmd_ready == 1'b1, "R2 ready after burst", cmd_ready, 1);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input int len);
    int w0 = wr_n, k = 0, t = 0; logic ok = 1'b1;
    send(1'b1, a, LW'(len));
    chk(wr_ready == 1'b1, "R6 wr_ready in burst", wr_ready, 1);
    while (k <= len && t < 500) begin
      wr_valid = (t % 3 != 1); wr_data = wdat(k);
      @(posedge clk);
      if (wr_valid && wr_ready) k++;
      @(negedge clk); t++;
    end
    wr_valid = 1'b0;
    wait_idle(rs_n);
    chk(wr_n - w0 == len + 1, "R6 write beat count", wr_n - w0, len + 1);
    for (int i = 0; i <= len; i++)
      if (wr_a[(w0 + i) % 256] != a + AW'(i) || wr_d[(w0 + i) % 256] != wdat(i)) ok = 1'b0;
    chk(ok, "R6 write addr/data with gaps", wr_d[w0 % 256], wdat(0));
  endtask

  task automatic t_credit();
    int r0 = rd_n, s0 = rs_n; logic okd = 1'b1;
    ret_en = 1'b0;
    send(1'b0, 16'h0200, LW'(19));
    repeat (30) @(negedge clk);
    chk(rd_n - r0 == MAX_OUT, "R7 stall at cap", rd_n - r0, MAX_OUT);
    chk(cmd_ready == 1'b0, "R7 burst still open", cmd_ready, 0);
    ret_en = 1'b1;
    wait_idle(s0 + 20);
    chk(rd_n - r0 == 20, "R7 burst completes", rd_n - r0, 20);
    for (int i = 0; i < 20; i++) if (rs_d[(s0 + i) % 256] != reg_val(16'h0200 + AW'(i))) okd = 1'b0;
    chk(okd, "R8 order after stall", rs_d[s0 % 256], reg_val(16'h0200));
  endtask

  task automatic t_ignore();
    int r0 = rd_n, s0 = rs_n;
    send(1'b0, 16'h0300, LW'(5));
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h7777; cmd_len = 8'd9;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle(s0 + 6);
    chk(rd_n - r0 == 6 && wr_n == wr_n, "R2 busy command ignored", rd_n - r0, 6);
    chk(rd_a[(r0 + 5) % 256] == 16'h0305, "R2 last addr from first cmd", rd_a[(r0 + 5) % 256], 16'h0305);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(16'h0010, 7);
    t_read(16'hFFFE, 0);
    t_write(16'h0100, 5);
    t_credit();
    t_ignore();
    t_read(16'h0400, 3);
    chk(v_both == 0, "R3 one transfer per cycle", v_both, 0);
    chk(v_out == 0, "R7 outstanding within cap", v_out, 0);
    chk(v_lat == 0, "R8 one cycle return latency", v_lat, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule